// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-visible face of an I2C master. A host reaches it through a byte-wide register port with an 18-byte window. It holds the controller's configuration and status bytes. It turns certain register accesses into high-level bus transactions: start with an address and direction, send a byte, receive a byte, and stop. These transactions go to a separate bit-level engine that drives SCL and SDA.

The transaction port uses a valid/ready request and a single-cycle response. The response carries an acknowledge flag and, for receives, the byte taken from the bus.

Some register accesses need bus transactions:
- writing the data byte,
- writing the control byte with the go flag set,
- writing the low master address while a transfer is open,
- reading the data byte while received data is flagged.

The block holds the register port's acknowledge back until every transaction that the access needs has completed. The block tracks whether a transfer is open with an internal busy flag. A successful start sets this flag, and any stop clears it.

Top module: `i2cm_regfront`

## Requirements
- R1: Mapped offsets are 0 data, 4 and 5 master address low and high, 6 control, 7 mode, 8 status, 9 extended status, 10 and 11 slave address low and high, 12 clock divider, 13 interrupt mask, 14 transfer count, 15 extended control, and 16 direct control. Every other offset reads 0x00 and ignores writes. Each access gets exactly one single-cycle `reg_ack`.
- R2: After reset, every register reads 0x00, except extended status, which reads 0x8F, and direct control, which reads 0x0F.
- R3: A write stores value & 0xDF in mode, value & 0x77 in transfer count, and value & 0x07 in direct control. The other plain registers store the full value.
- R4: A status write clears the status bits set in (value & 0x0A). An extended status write clears the bits set in (value & 0x8F). All other bits keep their value.
- R5: Writing offset 15 with bit 0 set returns every register to its R2 value and stores nothing. Writing offset 15 with bit 0 clear stores the value.
- R6: Every start carries the low master address shifted right by one, in `txn_data[6:0]` with bit 7 zero. Opcodes are 1 start-write, 2 start-read, 3 send, 4 receive and 5 stop. A request holds its opcode and data until it is accepted.
- R7: A data write while idle issues start-write and then sends the byte. A write while busy only sends the byte. An acknowledged start sets status bit 0, clears status bit 2 and zeroes extended status.
- R8: A data write whose start-write is not acknowledged clears status bit 0, sets status bit 2 and sets extended status bit 0. No byte is sent.
- R9: A data write whose sent byte is not acknowledged clears status bit 0, sets status bit 2, sets extended status bit 0 and then issues a stop.
- R10: A control write with bits 0 and 1 set works as follows. If busy, it clears status bit 0 and issues a stop. It then issues start-read. An acknowledged start-read sets status bit 5, clears status bit 2 and zeroes extended status. A nack sets status bit 2 and extended status bit 0.
- R11: A control write with bit 0 set and bit 1 clear clears status bit 0 and issues no transaction. The written value is stored as the control byte in every case.
- R12: A data read while status bit 5 is clear returns 0xFF. It issues no transaction and leaves the control byte unchanged.
- R13: A data read while status bit 5 is set issues a receive. It returns the received byte, or 0xFF if the receive is not acknowledged. The next step depends on the pending count in control bits 5:4. If the count is zero, the read clears status bit 5. If the count is nonzero, the read issues a stop and then a start-read. In both cases the count is decremented modulo 4, so 0 wraps to 3.
- R14: Writing the low master address while busy issues a stop. Writing it while idle issues no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with `reg_ack` |
| reg_ack | output | 1 | One-cycle completion pulse |
| txn_valid | output | 1 | Transaction request valid |
| txn_ready | input | 1 | Engine accepts the request |
| txn_op | output | 3 | Transaction opcode |
| txn_data | output | 8 | Address or byte to send |
| rsp_valid | input | 1 | One-cycle response from the engine, at least one cycle after acceptance |
| rsp_ack | input | 1 | Address or byte acknowledged / receive succeeded |
| rsp_data | input | 8 | Received byte |
| clk_div | output | 8 | Clock divider byte for the engine |

## Verification
The bench builds the block with the default window of 18 bytes, which gives a 5-bit offset. Offsets 17 through 31 are therefore reachable, and the bench probes offsets inside and beyond the window to confirm that they read as zero. A scripted bus target with a fixed 7-bit address lets the bench switch address acknowledgement, byte acknowledgement and receive success on and off. This brings every nack path within reach. It also covers the pending-count walk from 1 to 0 and the wrap from 0 to 3.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int OFS_DATA  = 0;
  localparam int OFS_MADL  = 4;
  localparam int OFS_MADH  = 5;
  localparam int OFS_CTRL  = 6;
  localparam int OFS_MODE  = 7;
  localparam int OFS_STAT  = 8;
  localparam int OFS_XSTAT = 9;
  localparam int OFS_SADL  = 10;
  localparam int OFS_SADH  = 11;
  localparam int OFS_CDIV  = 12;
  localparam int OFS_IMSK  = 13;
  localparam int OFS_XCNT  = 14;
  localparam int OFS_XCTL  = 15;
  localparam int OFS_DCTL  = 16;

  // control byte fields
  localparam int CT_GO   = 0;
  localparam int CT_RD   = 1;
  localparam int CT_PLO  = 4;
  // status byte fields
  localparam int ST_PT   = 0;
  localparam int ST_ERR  = 2;
  localparam int ST_HAVE = 5;
  // extended status field
  localparam int XS_ABRT = 0;

  localparam logic [7:0] MASK_MODE  = 8'hDF;
  localparam logic [7:0] MASK_XCNT  = 8'h77;
  localparam logic [7:0] MASK_DCTL  = 8'h07;
  localparam logic [7:0] MASK_STW1C = 8'h0A;
  localparam logic [7:0] MASK_XSW1C = 8'h8F;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_STARTW = 3'd1,
    OP_STARTR = 3'd2,
    OP_SEND   = 3'd3,
    OP_RECV   = 3'd4,
    OP_STOP   = 3'd5
  } op_e;

  typedef struct packed {
    logic [7:0] mdata;
    logic [7:0] madl;
    logic [7:0] madh;
    logic [7:0] ctrl;
    logic [7:0] mode;
    logic [7:0] stat;
    logic [7:0] xstat;
    logic [7:0] sadl;
    logic [7:0] sadh;
    logic [7:0] cdiv;
    logic [7:0] imsk;
    logic [7:0] xcnt;
    logic [7:0] xctl;
    logic [7:0] dctl;
  } regs_t;

  localparam regs_t REGS_RST = '{xstat: 8'h8F, dctl: 8'h0F, default: 8'h00};

endpackage

// File: rtl/i2cm_rdmux.sv
module i2cm_rdmux
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  regs_t             regs,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rdata
);

  always_comb begin
    rdata = 8'h00;
    case (int'(addr))
      OFS_DATA:  rdata = regs.mdata;
      OFS_MADL:  rdata = regs.madl;
      OFS_MADH:  rdata = regs.madh;
      OFS_CTRL:  rdata = regs.ctrl;
      OFS_MODE:  rdata = regs.mode;
      OFS_STAT:  rdata = regs.stat;
      OFS_XSTAT: rdata = regs.xstat;
      OFS_SADL:  rdata = regs.sadl;
      OFS_SADH:  rdata = regs.sadh;
      OFS_CDIV:  rdata = regs.cdiv;
      OFS_IMSK:  rdata = regs.imsk;
      OFS_XCNT:  rdata = regs.xcnt;
      OFS_XCTL:  rdata = regs.xctl;
      OFS_DCTL:  rdata = regs.dctl;
      default:   rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/i2cm_txn_port.sv
module i2cm_txn_port
  import i2cm_pkg::*;
#(
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic [OP_W-1:0] go_op,
  input  logic [7:0]      go_data,
  output logic            done,
  output logic            done_ack,
  output logic [7:0]      done_data,
  output logic            txn_valid,
  input  logic            txn_ready,
  output logic [OP_W-1:0] txn_op,
  output logic [7:0]      txn_data,
  input  logic            rsp_valid,
  input  logic            rsp_ack,
  input  logic [7:0]      rsp_data
);

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} pst_e;
  pst_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= P_IDLE;
      txn_valid <= 1'b0;
      txn_op    <= '0;
      txn_data  <= '0;
      done      <= 1'b0;
      done_ack  <= 1'b0;
      done_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        P_IDLE: if (go) begin
          txn_valid <= 1'b1;
          txn_op    <= go_op;
          txn_data  <= go_data;
          st        <= P_REQ;
        end
        P_REQ: if (txn_ready) begin
          txn_valid <= 1'b0;
          st        <= P_RSP;
        end
        P_RSP: if (rsp_valid) begin
          done      <= 1'b1;
          done_ack  <= rsp_ack;
          done_data <= rsp_data;
          st        <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  // R6: an offered request keeps its content until the engine takes it
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_op) && $stable(txn_data)));

  // R6: the sequencer never launches a request while one is outstanding
  assert_go_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    go |-> (st == P_IDLE));

endmodule

// File: rtl/i2cm_core.sv
module i2cm_core
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              reg_ack,
  input  logic [7:0]        mux_rdata,
  output regs_t             regs,
  output logic              go,
  output logic [OP_W-1:0]   go_op,
  output logic [7:0]        go_data,
  input  logic              done,
  input  logic              done_ack,
  input  logic [7:0]        done_data
);

  typedef enum logic [3:0] {
    C_IDLE, C_WD_START, C_WD_SEND, C_STOP_ACK, C_CT_STOP, C_CT_START,
    C_RD_RECV, C_RD_STOP, C_RD_START, C_HOLD
  } cst_e;

  cst_e        st;
  regs_t       r;
  logic        busy;
  logic [7:0]  tgt;
  logic [1:0]  pend;

  assign regs = r;
  assign tgt  = {1'b0, r.madl[7:1]};
  assign pend = r.ctrl[CT_PLO+1:CT_PLO];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      r         <= REGS_RST;
      busy      <= 1'b0;
      reg_ack   <= 1'b0;
      reg_rdata <= '0;
      go        <= 1'b0;
      go_op     <= '0;
      go_data   <= '0;
    end else begin
      go      <= 1'b0;
      reg_ack <= 1'b0;
      case (st)
        C_IDLE: if (reg_req) begin
          if (reg_we) begin
            reg_ack <= 1'b1;
            st      <= C_HOLD;
            case (int'(reg_addr))
              OFS_DATA: begin
                r.mdata <= reg_wdata;
                reg_ack <= 1'b0;
                go      <= 1'b1;
                if (!busy) begin
                  go_op   <= OP_W'(OP_STARTW);
                  go_data <= tgt;
                  st      <= C_WD_START;
                end else begin
                  go_op   <= OP_W'(OP_SEND);
                  go_data <= reg_wdata;
                  st      <= C_WD_SEND;
                end
              end
              OFS_MADL: begin
                r.madl <= reg_wdata;
                if (busy) begin
                  reg_ack <= 1'b0;
                  go      <= 1'b1;
                  go_op   <= OP_W'(OP_STOP);
                  go_data <= 8'h00;
                  st      <= C_STOP_ACK;
                end
              end
              OFS_CTRL: begin
                r.ctrl <= reg_wdata;
                if (reg_wdata[CT_GO]) begin
                  if (reg_wdata[CT_RD]) begin
                    reg_ack <= 1'b0;
                    go      <= 1'b1;
                    if (busy) begin
                      r.stat[ST_PT] <= 1'b0;
                      go_op   <= OP_W'(OP_STOP);
                      go_data <= 8'h00;
                      st      <= C_CT_STOP;
                    end else begin
                      go_op   <= OP_W'(OP_STARTR);
                      go_data <= tgt;
                      st      <= C_CT_START;
                    end
                  end else begin
                    r.stat[ST_PT] <= 1'b0;
                  end
                end
              end
              OFS_MADH:  r.madh  <= reg_wdata;
              OFS_MODE:  r.mode  <= reg_wdata & MASK_MODE;
              OFS_STAT:  r.stat  <= r.stat & ~(reg_wdata & MASK_STW1C);
              OFS_XSTAT: r.xstat <= r.xstat & ~(reg_wdata & MASK_XSW1C);
              OFS_SADL:  r.sadl  <= reg_wdata;
              OFS_SADH:  r.sadh  <= reg_wdata;
              OFS_CDIV:  r.cdiv  <= reg_wdata;
              OFS_IMSK:  r.imsk  <= reg_wdata;
              OFS_XCNT:  r.xcnt  <= reg_wdata & MASK_XCNT;
              OFS_XCTL: begin
                if (reg_wdata[0]) r <= REGS_RST;
                else              r.xctl <= reg_wdata;
              end
              OFS_DCTL:  r.dctl  <= reg_wdata & MASK_DCTL;
              default: ;
            endcase
          end else begin
            if (int'(reg_addr) == OFS_DATA) begin
              if (!r.stat[ST_HAVE]) begin
                reg_rdata <= 8'hFF;
                reg_ack   <= 1'b1;
                st        <= C_HOLD;
              end else begin
                go      <= 1'b1;
                go_op   <= OP_W'(OP_RECV);
                go_data <= 8'h00;
                st      <= C_RD_RECV;
              end
            end else begin
              reg_rdata <= mux_rdata;
              reg_ack   <= 1'b1;
              st        <= C_HOLD;
            end
          end
        end
        C_WD_START: if (done) begin
          if (done_ack) begin
            r.stat[ST_PT]  <= 1'b1;
            r.stat[ST_ERR] <= 1'b0;
            r.xstat        <= 8'h00;
            busy           <= 1'b1;
            go             <= 1'b1;
            go_op          <= OP_W'(OP_SEND);
            go_data        <= r.mdata;
            st             <= C_WD_SEND;
          end else begin
            r.stat[ST_PT]    <= 1'b0;
            r.stat[ST_ERR]   <= 1'b1;
            r.xstat[XS_ABRT] <= 1'b1;
            reg_ack          <= 1'b1;
            st               <= C_HOLD;
          end
        end
        C_WD_SEND: if (done) begin
          if (!done_ack) begin
            r.stat[ST_PT]    <= 1'b0;
            r.stat[ST_ERR]   <= 1'b1;
            r.xstat[XS_ABRT] <= 1'b1;
            go               <= 1'b1;
            go_op            <= OP_W'(OP_STOP);
            go_data          <= 8'h00;
            st               <= C_STOP_ACK;
          end else begin
            reg_ack <= 1'b1;
            st      <= C_HOLD;
          end
        end
        C_STOP_ACK: if (done) begin
          busy    <= 1'b0;
          reg_ack <= 1'b1;
          st      <= C_HOLD;
        end
        C_CT_STOP, C_RD_STOP: if (done) begin
          busy    <= 1'b0;
          go      <= 1'b1;
          go_op   <= OP_W'(OP_STARTR);
          go_data <= tgt;
          st      <= (st == C_CT_STOP) ? C_CT_START : C_RD_START;
        end
        C_CT_START, C_RD_START: if (done) begin
          if (done_ack) begin
            r.stat[ST_HAVE] <= 1'b1;
            r.stat[ST_ERR]  <= 1'b0;
            r.xstat         <= 8'h00;
            busy            <= 1'b1;
          end else begin
            r.stat[ST_PT]    <= 1'b0;
            r.stat[ST_ERR]   <= 1'b1;
            r.xstat[XS_ABRT] <= 1'b1;
          end
          reg_ack <= 1'b1;
          st      <= C_HOLD;
        end
        C_RD_RECV: if (done) begin
          reg_rdata <= done_ack ? done_data : 8'hFF;
          r.ctrl[CT_PLO+1:CT_PLO] <= pend - 2'd1;
          if (pend == 2'd0) begin
            r.stat[ST_HAVE] <= 1'b0;
            reg_ack         <= 1'b1;
            st              <= C_HOLD;
          end else begin
            go      <= 1'b1;
            go_op   <= OP_W'(OP_STOP);
            go_data <= 8'h00;
            st      <= C_RD_STOP;
          end
        end
        C_HOLD: st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  // R1: completion is a single-cycle pulse
  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    reg_ack |=> !reg_ack);

  // R4: after a status write the selected bits are clear
  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    (st == C_IDLE && reg_req && reg_we && int'(reg_addr) == OFS_STAT)
      |=> ((r.stat & ($past(reg_wdata) & MASK_STW1C)) == 8'h00));

  // R5: soft reset restores the whole register set
  assert_soft_reset_R5: assert property (@(posedge clk) disable iff (rst)
    (st == C_IDLE && reg_req && reg_we && int'(reg_addr) == OFS_XCTL && reg_wdata[0])
      |=> (r == REGS_RST));

  // R13: each completed receive lowers the pending count by one
  assert_pend_dec_R13: assert property (@(posedge clk) disable iff (rst)
    (st == C_RD_RECV && done) |=> (pend == $past(pend) - 2'd1));

endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
  import i2cm_pkg::*;
#(
  parameter int WINDOW = 18,
  parameter int OP_W   = 3,
  localparam int ADDR_W = $clog2(WINDOW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              reg_ack,
  output logic              txn_valid,
  input  logic              txn_ready,
  output logic [OP_W-1:0]   txn_op,
  output logic [7:0]        txn_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic [7:0]        rsp_data,
  output logic [7:0]        clk_div
);

  regs_t            regs;
  logic [7:0]       mux_rdata;
  logic             go, done, done_ack;
  logic [OP_W-1:0]  go_op;
  logic [7:0]       go_data, done_data;

  i2cm_core #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_core (
    .clk(clk), .rst(rst),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .mux_rdata(mux_rdata), .regs(regs),
    .go(go), .go_op(go_op), .go_data(go_data),
    .done(done), .done_ack(done_ack), .done_data(done_data)
  );

  i2cm_rdmux #(.ADDR_W(ADDR_W)) u_mux (
    .regs(regs), .addr(reg_addr), .rdata(mux_rdata)
  );

  i2cm_txn_port #(.OP_W(OP_W)) u_port (
    .clk(clk), .rst(rst),
    .go(go), .go_op(go_op), .go_data(go_data),
    .done(done), .done_ack(done_ack), .done_data(done_data),
    .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_op(txn_op), .txn_data(txn_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data)
  );

  assign clk_div = regs.cdiv;

endmodule

// File: tb/i2cm_regfront_tb_top.sv
module i2cm_regfront_tb_top;

  localparam logic [4:0] A_DATA = 5'd0, A_MADL = 5'd4, A_MADH = 5'd5,
    A_CTRL = 5'd6, A_MODE = 5'd7, A_STAT = 5'd8, A_XST = 5'd9,
    A_SADL = 5'd10, A_SADH = 5'd11, A_CDIV = 5'd12, A_IMSK = 5'd13,
    A_XCNT = 5'd14, A_XCTL = 5'd15, A_DCTL = 5'd16;
  localparam logic [2:0] K_SW = 3'd1, K_SR = 3'd2, K_TX = 3'd3,
    K_RX = 3'd4, K_SP = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_req = 0, reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic reg_ack, txn_valid;
  logic txn_ready = 1'b1;
  logic [2:0] txn_op;
  logic [7:0] txn_data;
  logic rsp_valid = 0, rsp_ack = 0;
  logic [7:0] rsp_data = '0, clk_div;

  int n_chk = 0, n_fail = 0;
  logic [2:0] lg_op [0:15];
  logic [7:0] lg_dat [0:15];
  int lg_n = 0;
  logic [6:0] tgt_addr = 7'h52;
  logic send_ok = 1, recv_ok = 1;
  logic [7:0] next_byte = 8'h81;

  always #2 clk = ~clk;

  i2cm_regfront dut_i (
    .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ack(reg_ack), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_op(txn_op), .txn_data(txn_data), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data), .clk_div(clk_div)
  );

  // scripted bus target
  initial begin
    logic have, a;
    logic [7:0] d;
    have = 0; a = 0; d = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (have) begin
        rsp_valid = 1; rsp_ack = a; rsp_data = d; have = 0;
      end else if (txn_valid) begin
        if (lg_n < 16) begin lg_op[lg_n] = txn_op; lg_dat[lg_n] = txn_data; end
        lg_n++;
        have = 1; d = 8'h00;
        case (txn_op)
          K_SW, K_SR: a = (txn_data[6:0] == tgt_addr) && !txn_data[7];
          K_TX: a = send_ok;
          K_RX: begin a = recv_ok; d = next_byte; next_byte = next_byte + 1; end
          default: a = 1;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk_n(input string req, input int exp);
    chk(req, 8'(lg_n), 8'(exp));
  endtask

  task automatic chk_op(input string req, input int i, input logic [2:0] op, input logic [7:0] d);
    chk(req, {5'd0, lg_op[i]}, {5'd0, op});
    chk(req, lg_dat[i], d);
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    do @(negedge clk); while (!reg_ack);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    do @(negedge clk); while (!reg_ack);
    d = reg_rdata;
    reg_req = 0;
  endtask

  task automatic expect_reg(input string req, input logic [4:0] a, input logic [7:0] e);
    logic [7:0] v;
    reg_rd(a, v);
    chk(req, v, e);
  endtask

  task automatic t_reset;
    expect_reg("R2 data", A_DATA, 8'hFF);
    expect_reg("R2 madl", A_MADL, 8'h00);
    expect_reg("R2 ctrl", A_CTRL, 8'h00);
    expect_reg("R2 stat", A_STAT, 8'h00);
    expect_reg("R2 xstat", A_XST, 8'h8F);
    expect_reg("R2 xctl", A_XCTL, 8'h00);
    expect_reg("R2 dctl", A_DCTL, 8'h0F);
    expect_reg("R1 gap 1", 5'd1, 8'h00);
    expect_reg("R1 gap 17", 5'd17, 8'h00);
    chk_n("R12 no txn at reset read", 0);
  endtask

  task automatic t_masks;
    reg_wr(A_MODE, 8'hFF); expect_reg("R3 mode", A_MODE, 8'hDF);
    reg_wr(A_XCNT, 8'hFF); expect_reg("R3 xcnt", A_XCNT, 8'h77);
    reg_wr(A_DCTL, 8'hFF); expect_reg("R3 dctl", A_DCTL, 8'h07);
    reg_wr(A_CDIV, 8'h9C); expect_reg("R3 cdiv", A_CDIV, 8'h9C);
    chk("R3 clk_div port", clk_div, 8'h9C);
    reg_wr(A_SADH, 8'h3E); expect_reg("R3 sadh", A_SADH, 8'h3E);
    reg_wr(5'd2, 8'hFF); expect_reg("R1 gap 2 write ignored", 5'd2, 8'h00);
    reg_wr(5'd20, 8'hFF); expect_reg("R1 beyond window", 5'd20, 8'h00);
    reg_wr(A_XST, 8'h0F); expect_reg("R4 xstat w1c", A_XST, 8'h80);
    chk_n("R1 plain writes no txn", 0);
  endtask

  task automatic t_write_idle;
    reg_wr(A_MADL, 8'hA5);
    chk_n("R14 idle madl no txn", 0);
    reg_wr(A_DATA, 8'h3C);
    chk_n("R7 write count", 2);
    chk_op("R6 start addr", 0, K_SW, 8'h52);
    chk_op("R7 send byte", 1, K_TX, 8'h3C);
    expect_reg("R7 stat", A_STAT, 8'h01);
    expect_reg("R7 xstat", A_XST, 8'h00);
    lg_n = 0;
  endtask

  task automatic t_madl_busy;
    reg_wr(A_MADL, 8'hA4);
    chk_n("R14 stop count", 1);
    chk_op("R14 stop", 0, K_SP, 8'h00);
    lg_n = 0;
    reg_wr(A_MADL, 8'hA4);
    chk_n("R14 idle again", 0);
  endtask

  task automatic t_addr_nack;
    reg_wr(A_MADL, 8'h20);
    reg_wr(A_DATA, 8'h11);
    chk_n("R8 only start", 1);
    chk_op("R8 start addr", 0, K_SW, 8'h10);
    expect_reg("R8 stat", A_STAT, 8'h04);
    expect_reg("R8 xstat", A_XST, 8'h01);
    reg_wr(A_STAT, 8'hFF); expect_reg("R4 stat err kept", A_STAT, 8'h04);
    reg_wr(A_XST, 8'h81);  expect_reg("R4 xstat cleared", A_XST, 8'h00);
    lg_n = 0;
  endtask

  task automatic t_byte_nack;
    reg_wr(A_MADL, 8'hA4);
    send_ok = 0;
    reg_wr(A_DATA, 8'h55);
    send_ok = 1;
    chk_n("R9 count", 3);
    chk_op("R9 send", 1, K_TX, 8'h55);
    chk_op("R9 stop", 2, K_SP, 8'h00);
    expect_reg("R9 stat", A_STAT, 8'h04);
    expect_reg("R9 xstat", A_XST, 8'h01);
    lg_n = 0;
  endtask

  task automatic t_ctrl_read;
    reg_wr(A_DATA, 8'h66);
    expect_reg("R7 stat before read", A_STAT, 8'h01);
    lg_n = 0;
    reg_wr(A_CTRL, 8'h13);
    chk_n("R10 count", 2);
    chk_op("R10 stop first", 0, K_SP, 8'h00);
    chk_op("R10 start read", 1, K_SR, 8'h52);
    expect_reg("R10 stat", A_STAT, 8'h20);
    expect_reg("R10 ctrl", A_CTRL, 8'h13);
    lg_n = 0;
  endtask

  task automatic t_data_read;
    logic [7:0] v;
    next_byte = 8'h81;
    reg_rd(A_DATA, v);
    chk("R13 first byte", v, 8'h81);
    chk_n("R13 restart count", 3);
    chk_op("R13 recv", 0, K_RX, 8'h00);
    chk_op("R13 stop", 1, K_SP, 8'h00);
    chk_op("R13 restart", 2, K_SR, 8'h52);
    expect_reg("R13 pend 1->0", A_CTRL, 8'h03);
    expect_reg("R13 have kept", A_STAT, 8'h20);
    lg_n = 0;
    reg_rd(A_DATA, v);
    chk("R13 second byte", v, 8'h82);
    chk_n("R13 recv only", 1);
    expect_reg("R13 pend wrap", A_CTRL, 8'h33);
    expect_reg("R13 have cleared", A_STAT, 8'h00);
    lg_n = 0;
    reg_rd(A_DATA, v);
    chk("R12 empty read", v, 8'hFF);
    chk_n("R12 no txn", 0);
    expect_reg("R12 ctrl unchanged", A_CTRL, 8'h33);
    reg_wr(A_CTRL, 8'h03);
    lg_n = 0;
    recv_ok = 0;
    reg_rd(A_DATA, v);
    recv_ok = 1;
    chk("R13 failed fetch", v, 8'hFF);
    expect_reg("R13 have cleared on fail", A_STAT, 8'h00);
    lg_n = 0;
  endtask

  task automatic t_ctrl_write_only;
    reg_wr(A_MADL, 8'hA4);
    reg_wr(A_DATA, 8'h77);
    expect_reg("R11 stat before", A_STAT, 8'h01);
    lg_n = 0;
    reg_wr(A_CTRL, 8'h01);
    chk_n("R11 no txn", 0);
    expect_reg("R11 pt cleared", A_STAT, 8'h00);
    expect_reg("R11 ctrl stored", A_CTRL, 8'h01);
  endtask

  task automatic t_ctrl_nack;
    reg_wr(A_MADL, 8'h20);
    lg_n = 0;
    reg_wr(A_CTRL, 8'h03);
    chk_n("R10 nack count", 1);
    chk_op("R10 nack start", 0, K_SR, 8'h10);
    expect_reg("R10 nack stat", A_STAT, 8'h04);
    expect_reg("R10 nack xstat", A_XST, 8'h01);
    lg_n = 0;
  endtask

  task automatic t_soft_reset;
    reg_wr(A_XCTL, 8'h02); expect_reg("R5 stored", A_XCTL, 8'h02);
    reg_wr(A_IMSK, 8'h5A);
    reg_wr(A_DCTL, 8'h01);
    reg_wr(A_XCTL, 8'h01);
    expect_reg("R5 xctl", A_XCTL, 8'h00);
    expect_reg("R5 imsk", A_IMSK, 8'h00);
    expect_reg("R5 madl", A_MADL, 8'h00);
    expect_reg("R5 stat", A_STAT, 8'h00);
    expect_reg("R5 xstat", A_XST, 8'h8F);
    expect_reg("R5 dctl", A_DCTL, 8'h0F);
    expect_reg("R5 mode", A_MODE, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset;
    t_masks;
    t_write_idle;
    t_madl_busy;
    t_addr_nack;
    t_byte_nack;
    t_ctrl_read;
    t_data_read;
    t_ctrl_write_only;
    t_ctrl_nack;
    t_soft_reset;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule